// File: doc/BRIEF.md
# Stepped-Duty Boost PWM Controller

This block is the digital control core of a boost DC-DC converter. A comparator outside the block reports whether the regulated feedback voltage sits below its reference. The block filters that bit and moves a duty value up or down by exactly one slot per switching period. It drives the power transistor gate with a pulse whose width is that duty value.

The switching period is a fixed number of system clock cycles, sixteen by default. Each clock cycle of a period is one duty slot. The gate is driven high for the first N slots of a period, where N is the current duty value. N can never exceed a cap, twelve slots by default, which is 75 %. When the filtered comparator bit says the feedback is low, N climbs. When it says the feedback is high, N falls toward zero. Because the staircase moves one slot per period, the output approaches regulation without a large proportional jump.

An active-low shutdown input turns the gate off at once and holds every internal state at its starting value. After reset or shutdown, control begins again from zero duty with an empty filter.

Top module: `boost_pwm_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_drv` is 0. After reset is released, the first period runs at zero duty.
- R2: One switching period is SLOTS clock cycles long, where slot 0 is the first cycle after reset or shutdown release. In slot s, `gate_drv` is 1 exactly when s is less than the current duty N.
- R3: `fb_low` is sampled once per period, in the last slot. The filtered bit starts at 0 and takes the sampled value only after RUN_LEN (4) consecutive samples that differ from it. A shorter run of differing samples leaves the duty staircase unchanged.
- R4: At each period boundary where the filtered bit is 1, N rises by one slot.
- R5: N never exceeds DUTY_MAX (12 of 16 slots). Once N is at the cap, further rising steps hold it there.
- R6: At each period boundary where the filtered bit is 0, N falls by one slot. N stops at 0.
- R7: N changes only at period boundaries and never by more than one slot at a time. The filtered bit also changes only at period boundaries.
- R8: While `shutdown_n` is 0, `gate_drv` is 0 in the same cycle, with no clock edge needed.
- R9: Releasing `shutdown_n` restarts the controller at slot 0 with zero duty and an empty filter. A fresh run of RUN_LEN low-feedback samples is then needed before N rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one cycle is one duty slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown_n | input | 1 | Active-low shutdown; 0 forces the gate off and clears all state |
| fb_low | input | 1 | Comparator bit; 1 means the feedback is below the reference |
| gate_drv | output | 1 | Power transistor gate drive |

## Verification
A wrong duty value shows up within the very next period as a pulse of the wrong width at `gate_drv`. A wrong slot counter shows up the same way, as a pulse at the wrong position. A filter that changes too early or too late shifts the start of the staircase by whole periods. The bench therefore sees it as a ramp that begins one or more periods away from the fifth period of a steady input. State left over after shutdown is exposed by the first periods after restart. A surviving filter value, or a surviving duty, produces pulses where zero width is expected.

// File: rtl/boost_pwm_pkg.sv
package boost_pwm_pkg;

  // Next staircase level: one slot up to the cap, or one slot down to zero.
  function automatic int unsigned step_duty(int unsigned cur, logic raise, int unsigned cap);
    if (raise) return (cur >= cap) ? cap : cur + 1;
    else       return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Gate is on in the leading slots of a period.
  function automatic logic slot_active(int unsigned slot, int unsigned level);
    return slot < level;
  endfunction

endpackage

// File: rtl/slot_divider.sv
module slot_divider #(
  parameter int SLOTS = 16,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [SW-1:0] slot_q,
  output logic          period_end
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  assign period_end = !clr && (slot_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          slot_q <= '0;
    else if (clr)        slot_q <= '0;
    else if (period_end) slot_q <= '0;
    else                 slot_q <= slot_q + SW'(1);
  end
endmodule

// File: rtl/fb_deglitch.sv
module fb_deglitch #(
  parameter int RUN_LEN = 4,
  localparam int CW = $clog2(RUN_LEN) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sample,
  input  logic raw,
  output logic filt_q
);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (clr) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (sample) begin
      if (raw == filt_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        filt_q <= raw;
        run_q  <= '0;
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/duty_stepper.sv
module duty_stepper
  import boost_pwm_pkg::*;
#(
  parameter int DUTY_MAX = 12,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          raise,
  output logic [DW-1:0] duty_q
);
  logic [DW-1:0] duty_next;

  assign duty_next = DW'(step_duty(32'(duty_q), raise, DUTY_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_q <= '0;
    else if (clr)  duty_q <= '0;
    else if (step) duty_q <= duty_next;
  end
endmodule

// File: rtl/boost_pwm_ctrl.sv
module boost_pwm_ctrl
  import boost_pwm_pkg::*;
#(
  parameter int SLOTS    = 16,
  parameter int DUTY_MAX = 12,
  parameter int RUN_LEN  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shutdown_n,
  input  logic fb_low,
  output logic gate_drv
);
  localparam int SW = $clog2(SLOTS);
  localparam int DW = $clog2(SLOTS + 1);

  // Named internal events, brought out for the bound checker.
  logic          hold_clr;
  logic [SW-1:0] slot_q;
  logic          period_end;
  logic          filt_q;
  logic [DW-1:0] duty_q;

  assign hold_clr = !shutdown_n;

  slot_divider #(.SLOTS(SLOTS)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr),
    .slot_q(slot_q), .period_end(period_end)
  );

  fb_deglitch #(.RUN_LEN(RUN_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr),
    .sample(period_end), .raw(fb_low), .filt_q(filt_q)
  );

  duty_stepper #(.DUTY_MAX(DUTY_MAX), .DW(DW)) u_step (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr),
    .step(period_end), .raise(filt_q), .duty_q(duty_q)
  );

  assign gate_drv = rst_n && shutdown_n && slot_active(32'(slot_q), 32'(duty_q));
endmodule

// File: rtl/boost_pwm_chk.sv
module boost_pwm_chk #(
  parameter int SW = 4,
  parameter int DW = 5,
  parameter int DUTY_MAX = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shutdown_n,
  input logic          gate_drv,
  input logic [SW-1:0] slot_q,
  input logic          period_end,
  input logic          filt_q,
  input logic [DW-1:0] duty_q
);
  a_r5_duty_cap: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= DW'(DUTY_MAX));

  a_r7_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_n && $past(shutdown_n) && !$past(period_end)) |-> $stable(duty_q));

  a_r7_filt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_n && $past(shutdown_n) && !$past(period_end)) |-> $stable(filt_q));

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_n && $past(shutdown_n)) |->
      (duty_q == $past(duty_q)) || (duty_q == $past(duty_q) + DW'(1)) ||
      ($past(duty_q) == duty_q + DW'(1)));

  a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_n |-> !gate_drv);

  a_r2_gate_shape: assert property (@(posedge clk) disable iff (!rst_n)
    gate_drv |-> ({1'b0, slot_q} < {{(SW+1){1'b0}}, duty_q}));

  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (slot_q == '0));
endmodule

bind boost_pwm_ctrl boost_pwm_chk #(.SW(SW), .DW(DW), .DUTY_MAX(DUTY_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown_n(shutdown_n), .gate_drv(gate_drv),
  .slot_q(slot_q), .period_end(period_end), .filt_q(filt_q), .duty_q(duty_q)
);

// File: tb/boost_pwm_ctrl_bench.sv
`timescale 1ns/1ps
module boost_pwm_ctrl_bench;
  localparam int SLOTS = 16;
  localparam int CAP   = 12;
  localparam int RUNL  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutdown_n = 1'b1;
  logic fb_low = 1'b0;
  logic gate_drv;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Bench-side model of the staircase, kept at period granularity.
  int m_level = 0;
  int m_filt = 0;
  int m_streak = 0;

  always #2.5 clk = ~clk;

  boost_pwm_ctrl u_boost_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .shutdown_n(shutdown_n),
    .fb_low(fb_low), .gate_drv(gate_drv)
  );

  task automatic check_bit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: gate_drv=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_restart();
    m_level = 0; m_filt = 0; m_streak = 0;
  endtask

  // Entered and left at a falling edge in slot 0.
  task automatic run_period(string tag, logic fb);
    logic [SLOTS-1:0] act;
    logic [SLOTS-1:0] exp;
    for (int s = 0; s < SLOTS; s++) begin
      if (s == 0) fb_low = fb;
      act[s] = gate_drv;
      exp[s] = (s < m_level);
      @(negedge clk);
    end
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pattern=%b expected %b (level %0d)", tag, act, exp, m_level);
    end
    // boundary: level moves on the old filter value, then filter samples fb
    if (m_filt == 1) m_level = (m_level + 1 > CAP) ? CAP : m_level + 1;
    else             m_level = (m_level == 0) ? 0 : m_level - 1;
    if (int'(fb) == m_filt) m_streak = 0;
    else begin
      m_streak++;
      if (m_streak == RUNL) begin m_filt = int'(fb); m_streak = 0; end
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R1 reset gate low", gate_drv, 1'b0);
    rst_n = 1'b1;
    model_restart();

    // R1 R3 R4: steady low feedback, ramp starts after the filter fills
    for (int p = 0; p < 6; p++) run_period("R1 R3 R4 startup", 1'b1);
    // R4 R5: climb to the cap and hold there
    for (int p = 0; p < 16; p++) run_period("R4 R5 climb and cap", 1'b1);
    // R3: runs of three differing samples must not move the staircase
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 3; p++) run_period("R3 short run ignored", 1'b0);
      run_period("R3 short run ignored", 1'b1);
    end
    // R6: descend to zero and floor
    for (int p = 0; p < 20; p++) run_period("R6 descend and floor", 1'b0);
    // ramp up again before shutdown
    for (int p = 0; p < 10; p++) run_period("R4 second ramp", 1'b1);

    // R8: shutdown at slot 0 with a nonzero level
    check_bit("R8 gate high before shutdown", gate_drv, 1'b1);
    shutdown_n = 1'b0;
    #1;
    check_bit("R8 immediate gate off", gate_drv, 1'b0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check_bit("R8 gate held off", gate_drv, 1'b0);
    end
    shutdown_n = 1'b1;
    model_restart();
    // R9: filter and level cleared; ramp again needs a full run
    for (int p = 0; p < 7; p++) run_period("R9 restart from zero", 1'b1);

    // R2 R3 R4 R6: sweep all 5-bit feedback patterns, one bit per period
    for (int v = 0; v < 32; v++)
      for (int b = 0; b < 5; b++)
        run_period("R2 R3 R4 R6 pattern sweep", v[b]);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule